// File: doc/BRIEF.md
# Processor status flag register

This block holds the flag word that a small 8-bit core consults after each data operation. Four arithmetic flags live in the low nibble: carry, half carry, zero and overflow. The ALU can refresh each of them through its own enable line, and a bus write can overwrite all four at once. Two power-management flags sit above them. One records that the core went to sleep and the other records that the watchdog expired. Software cannot write either of these two flags. Each changes only on a dedicated event pulse from the power-up, watchdog-clear, halt or time-out logic.

The register is read back as one 8-bit word and its top two bits always read zero. Nothing saves the word automatically when the core takes an interrupt or calls a subroutine. Firmware that needs the flags to survive must copy them out first. The reset is asynchronous and active low. The block releases it synchronously, two clock edges after the input rises.

Top module: `pwr_status_reg`

## Requirements
- R1: While reset is held, and after it is released with no other stimulus, rd_data reads 0x00. An assertion of rst_n low in the middle of a run returns the register to 0x00.
- R2: A cycle with wr_en high loads wr_data[3:0] into carry (bit 0), half carry (bit 1), zero (bit 2) and overflow (bit 3). The new value is visible on rd_data after that clock edge.
- R3: With wr_en low, each arithmetic flag whose alu_upd bit is high (alu_upd[i] selects rd_data bit i) takes alu_flags[i]. Flags whose enable is low keep their value.
- R4: When wr_en and any alu_upd bit are high in the same cycle, every arithmetic flag takes the bus value.
- R5: A bus write never changes the sleep flag (bit 4) or the time-out flag (bit 5), whatever wr_data[5:4] holds.
- R6: rd_data[7:6] always reads 0, even after a write of 1s to those bits.
- R7: A halt pulse sets the sleep flag. A power-up or watchdog-clear pulse clears it, and a clear wins over a halt in the same cycle.
- R8: A time-out pulse sets the time-out flag. A power-up, watchdog-clear or halt pulse clears it, and any of these clears wins over a time-out in the same cycle.
- R9: Power-up has the highest priority and clears both power flags, whatever other pulses arrive with it. It leaves the arithmetic flags untouched.
- R10: A cycle with no write, no ALU enable and no event pulse leaves all bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Current register contents |
| alu_flags | input | 4 | ALU flag values {ov, z, ac, c} |
| alu_upd | input | 4 | Per-flag ALU update enables |
| ev_powerup | input | 1 | Power-up event pulse |
| ev_wdt_clr | input | 1 | Watchdog-clear instruction pulse |
| ev_halt | input | 1 | Halt instruction pulse |
| ev_timeout | input | 1 | Watchdog time-out pulse |

## Verification
Two kinds of same-cycle collision matter here. The first is an ALU flag refresh arriving in the same cycle as a bus write. The second is a time-out or halt pulse arriving in the same cycle as one of the clearing events. The table drives these collisions in single cycles: all ALU enables together with a write of opposite data, time-out together with watchdog clear, halt together with time-out, and power-up together with halt and time-out. Each result is judged from rd_data on the cycle after the edge, against the priority order the requirements state.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int STAT_W   = 8;
  localparam int ARITH_N  = 4;
  localparam int BIT_SLP  = 4;
  localparam int BIT_TMO  = 5;

  typedef struct packed {
    logic timeout;
    logic halt;
    logic wdt_clr;
    logic powerup;
  } pwr_ev_t;
endpackage

// File: rtl/stat_arith_flags.sv
module stat_arith_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [N-1:0] bus_d,
  input  logic [N-1:0] alu_en,
  input  logic [N-1:0] alu_d,
  output logic [N-1:0] q
);
  logic [N-1:0] nxt;
  logic [N-1:0] ld;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      ld[i]  = bus_we | alu_en[i];
      nxt[i] = bus_we ? bus_d[i] : alu_d[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= 1'b0;
      else if (ld[i]) q[i] <= nxt[i];
    end

    // R3: an ALU enable alone loads that flag
    p_alu_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && alu_en[i]) |=> q[i] == $past(alu_d[i]));

    // R10: no source selected keeps the flag
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && !alu_en[i]) |=> $stable(q[i]));
  end

  // R4: bus data wins over any ALU enable
  p_bus_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> q == $past(bus_d));
endmodule

// File: rtl/stat_power_flags.sv
module stat_power_flags
  import stat_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pwr_ev_t ev,
  output logic    slp_q,
  output logic    tmo_q
);
  logic slp_nxt, tmo_nxt;
  logic slp_ld, tmo_ld;

  always_comb begin
    slp_ld  = ev.powerup | ev.wdt_clr | ev.halt;
    slp_nxt = !(ev.powerup | ev.wdt_clr);
    tmo_ld  = ev.powerup | ev.wdt_clr | ev.halt | ev.timeout;
    tmo_nxt = !(ev.powerup | ev.wdt_clr | ev.halt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      slp_q <= 1'b0;
    else if (slp_ld) slp_q <= slp_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo_q <= 1'b0;
    else if (tmo_ld) tmo_q <= tmo_nxt;
  end

  p_slp_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.halt && !ev.powerup && !ev.wdt_clr) |=> slp_q);
  p_slp_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.powerup || ev.wdt_clr) |=> !slp_q);
  p_tmo_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.timeout && !ev.powerup && !ev.wdt_clr && !ev.halt) |=> tmo_q);
  p_tmo_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.powerup || ev.wdt_clr || ev.halt) |=> !tmo_q);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == '0) |=> ($stable(slp_q) && $stable(tmo_q)));
endmodule

// File: rtl/pwr_status_reg.sv
module pwr_status_reg
  import stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] rd_data,
  input  logic [ARITH_N-1:0] alu_flags,
  input  logic [ARITH_N-1:0] alu_upd,
  input  logic              ev_powerup,
  input  logic              ev_wdt_clr,
  input  logic              ev_halt,
  input  logic              ev_timeout
);
  logic [1:0]         rst_sync;
  logic               rst_q_n;
  logic [ARITH_N-1:0] arith_q;
  logic               slp_q, tmo_q;
  pwr_ev_t            ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  always_comb begin
    ev.powerup = ev_powerup;
    ev.wdt_clr = ev_wdt_clr;
    ev.halt    = ev_halt;
    ev.timeout = ev_timeout;
  end

  stat_arith_flags #(.N(ARITH_N)) u_arith (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .bus_we (wr_en),
    .bus_d  (wr_data[ARITH_N-1:0]),
    .alu_en (alu_upd),
    .alu_d  (alu_flags),
    .q      (arith_q)
  );

  stat_power_flags u_power (
    .clk   (clk),
    .rst_n (rst_q_n),
    .ev    (ev),
    .slp_q (slp_q),
    .tmo_q (tmo_q)
  );

  always_comb begin
    rd_data                   = '0;
    rd_data[ARITH_N-1:0]      = arith_q;
    rd_data[BIT_SLP]          = slp_q;
    rd_data[BIT_TMO]          = tmo_q;
  end

  // R5: a write with no event leaves the power bits alone
  p_wr_keeps_power_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && ev == '0) |=> $stable(rd_data[BIT_TMO:BIT_SLP]));

  // R9: power-up leaves the arithmetic flags to their own sources
  p_pu_arith_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ev_powerup && !wr_en && alu_upd == '0) |=> $stable(rd_data[ARITH_N-1:0]));
endmodule

// File: tb/tb_pwr_status_reg.sv
module tb_pwr_status_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] alu_flags = '0;
  logic [3:0] alu_upd = '0;
  logic       ev_powerup = 1'b0, ev_wdt_clr = 1'b0, ev_halt = 1'b0, ev_timeout = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_status_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .alu_flags(alu_flags), .alu_upd(alu_upd), .ev_powerup(ev_powerup),
    .ev_wdt_clr(ev_wdt_clr), .ev_halt(ev_halt), .ev_timeout(ev_timeout)
  );

  // {wr_en, wr_data, alu_upd, alu_flags, ev{timeout,halt,clr,powerup}, expected}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b1, 8'hFF, 4'h0, 4'h0, 4'b0000, 8'h0F},  // R2 R5 R6
    {1'b0, 8'h00, 4'h5, 4'h0, 4'b0000, 8'h0A},  // R3
    {1'b1, 8'h30, 4'hF, 4'hF, 4'b0000, 8'h00},  // R4 R5
    {1'b0, 8'h00, 4'h0, 4'h0, 4'b0100, 8'h10},  // R7 halt sets
    {1'b0, 8'h00, 4'h0, 4'h0, 4'b1000, 8'h30},  // R8 timeout sets
    {1'b1, 8'h00, 4'h0, 4'h0, 4'b0000, 8'h30},  // R5 write keeps power bits
    {1'b0, 8'h00, 4'h0, 4'h0, 4'b0000, 8'h30},  // R10 idle
    {1'b0, 8'h00, 4'h0, 4'h0, 4'b1010, 8'h00},  // R7 R8 clear beats timeout
    {1'b0, 8'h00, 4'h0, 4'h0, 4'b1100, 8'h10},  // R8 halt beats timeout
    {1'b0, 8'h00, 4'h0, 4'h0, 4'b1000, 8'h30},  // R8
    {1'b0, 8'h00, 4'h0, 4'h0, 4'b1101, 8'h00},  // R9 power-up first
    {1'b0, 8'h00, 4'h8, 4'h8, 4'b0000, 8'h08},  // R3 overflow only
    {1'b0, 8'h00, 4'h0, 4'h0, 4'b0100, 8'h18},  // R7
    {1'b0, 8'h00, 4'h0, 4'h0, 4'b0010, 8'h08}   // R7 clear
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";   1: return "R3";   2: return "R4";   3: return "R7";
      4: return "R8";   5: return "R5";   6: return "R10";  7: return "R7";
      8: return "R8";   9: return "R8";   10: return "R9";  11: return "R3";
      12: return "R7";  default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic apply(logic we, logic [7:0] d, logic [3:0] upd, logic [3:0] fl, logic [3:0] ev);
    @(negedge clk);
    wr_en = we; wr_data = d; alu_upd = upd; alu_flags = fl;
    {ev_timeout, ev_halt, ev_wdt_clr, ev_powerup} = ev;
    @(posedge clk);
    #1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; alu_upd = '0; alu_flags = '0;
    {ev_timeout, ev_halt, ev_wdt_clr, ev_powerup} = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", rd_data, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][28], VEC[i][27:20], VEC[i][19:16], VEC[i][15:12], VEC[i][11:8]);
      check(tag_of(i), rd_data, VEC[i][7:0]);
    end

    // R6: top bits written with 1s read back as zero
    apply(1'b1, 8'hC0, 4'h0, 4'h0, 4'b0000);
    check("R6", {rd_data[7:6], 6'b0}, 8'h00);

    // R9: power-up with an arithmetic flag set leaves it alone
    apply(1'b1, 8'h04, 4'h0, 4'h0, 4'b0000);
    apply(1'b0, 8'h00, 4'h0, 4'h0, 4'b0100);
    check("R7", rd_data, 8'h14);
    apply(1'b0, 8'h00, 4'h0, 4'h0, 4'b0001);
    check("R9", rd_data, 8'h04);

    // R1: reset in mid-run
    apply(1'b0, 8'h00, 4'h0, 4'h0, 4'b1000);
    check("R8", rd_data, 8'h24);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R1", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", rd_data, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule